// File: doc/BRIEF.md
# Serial Receive Master with Gated Start Trigger

This block is the receive side of a clocked serial master. It generates the serial clock, shifts in 8-bit frames with the most significant bit first, and places each finished frame in a receive data register. It also decides when each transfer may begin. A separate start-enable bit in the control register gates both ways a receive transfer can begin:

- a read of the receive data register, which starts the next reception;
- the automatic back-to-back continuation used in continuous mode.

Software drives the block over a small register bus. There are three registers: control at address 0, status at address 1, and receive data at address 2.

- **Single mode.** Each read of the data register collects a frame and starts the next one. Before the final read, software clears the start enable so that the read launches nothing.
- **Continuous mode.** The block keeps streaming frames for as long as the start enable is still set when the last bit of the current frame begins.
- **Transmit and transmit/receive modes.** These are modelled only to the point that the start enable plays no part. In those modes a write to the data register starts a transfer.

Top module: `spi_rx_start_ctrl`

## Requirements
- R1: In receive modes (control bit 5 = 0), no transfer starts while the start-enable bit (control bit 0) is 0, whether by a data register read or by continuation.
- R2: With power (control bit 7) and receive enable (control bit 6) set, control bit 5 = 0 and control bit 0 = 1, a read of address 2 while idle starts an 8-bit transfer, and status bit 0 (busy) reads 1 on the next cycle.
- R3: In single mode (control bit 4 = 0), clearing control bit 0 before the last read of address 2 makes that read return the frame and start nothing: busy stays 0, the serial clock stays low and no interrupt follows.
- R4: In continuous mode (control bit 4 = 1), the start enable is sampled at the serial clock falling edge that begins bit 7. If it is 1 there, the next frame follows with no gap, and consecutive interrupts are exactly 16*DIV_HALF clock cycles apart. If it is 0 there, the block stops after the current frame. Clearing it after that edge costs exactly one more frame.
- R5: With control bit 5 = 1, control bit 0 has no effect. A read of address 2 starts nothing, and a write to address 2 starts a transfer whose received frame is captured normally.
- R6: Data is sampled on serial clock rising edges, MSB first. When a frame completes, the receive interrupt is high for exactly one cycle, and the data register holds the frame from that cycle on.
- R7: Status bit 0 is 1 exactly while a transfer runs. No transfer starts unless control bits 7 and 6 are both 1, and those bits are cleared only while status bit 0 is 0.
- R8: After a stop, setting control bit 0 and performing a dummy read of address 2 starts a new reception.
- R9: Control bits 3 to 1 always read 0 and ignore writes.
- R10: Status bit 2 flags an unread frame and is cleared by reading address 2. If a frame completes while status bit 2 is set, the new frame overwrites the data register and sticky status bit 1 is set. Writing 1 to status bit 1 clears it.
- R11: After reset, all registers read 0, the serial clock is low and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (read side effects) |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the addressed register |
| sck_o | output | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data in |
| rx_irq_o | output | 1 | Receive-complete pulse |

## Verification
The assertions rely on software to follow the documented stop procedure. They assume that the power and receive-enable bits never drop while a transfer is in flight, and that a start never coincides with a control write that changes those bits. The bench respects both rules: it checks the busy flag before reaching idle, and it changes only the start-enable, mode and transmit bits during streaming.

Serial input is produced by a model slave. The slave advances one bit per serial clock falling edge, so sampled data stays stable around every rising edge.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int REG_W   = 8;
  localparam int FRAME_W = 8;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_STAT = 2'd1,
    ADR_DATA = 2'd2,
    ADR_NONE = 2'd3
  } reg_addr_e;

  // control bit positions
  localparam int C_PWR   = 7;
  localparam int C_RX    = 6;
  localparam int C_TX    = 5;
  localparam int C_CONT  = 4;
  localparam int C_START = 0;

  // status bit positions
  localparam int S_BUSY = 0;
  localparam int S_OVR  = 1;
  localparam int S_FULL = 2;

  typedef struct packed {
    logic pwr;
    logic rx_en;
    logic tx_mode;
    logic cont;
    logic start_en;
  } ctrl_t;
endpackage

// File: rtl/spi_rx_regs.sv
module spi_rx_regs
  import spi_rx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic               busy_i,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] frame_i,
  output ctrl_t              ctrl_o,
  output logic               rd_data_o,
  output logic               wr_data_o
);
  ctrl_t              ctrl_q;
  logic [FRAME_W-1:0] data_q;
  logic               full_q, ovr_q;
  logic               wr_ctrl, wr_stat;

  assign rd_data_o = rd_i && (addr_i == ADR_DATA);
  assign wr_data_o = wr_i && (addr_i == ADR_DATA);
  assign wr_ctrl   = wr_i && (addr_i == ADR_CTRL);
  assign wr_stat   = wr_i && (addr_i == ADR_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.pwr      <= wdata_i[C_PWR];
      ctrl_q.rx_en    <= wdata_i[C_RX];
      ctrl_q.tx_mode  <= wdata_i[C_TX];
      ctrl_q.cont     <= wdata_i[C_CONT];
      ctrl_q.start_en <= wdata_i[C_START];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (done_i) data_q <= frame_i;
      full_q <= done_i || (full_q && !rd_data_o);
      // set wins over software clear
      if (done_i && full_q && !rd_data_o) ovr_q <= 1'b1;
      else if (wr_stat && wdata_i[S_OVR]) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL: begin
        rdata_o[C_PWR]   = ctrl_q.pwr;
        rdata_o[C_RX]    = ctrl_q.rx_en;
        rdata_o[C_TX]    = ctrl_q.tx_mode;
        rdata_o[C_CONT]  = ctrl_q.cont;
        rdata_o[C_START] = ctrl_q.start_en;
      end
      ADR_STAT: begin
        rdata_o[S_BUSY] = busy_i;
        rdata_o[S_OVR]  = ovr_q;
        rdata_o[S_FULL] = full_q;
      end
      ADR_DATA: rdata_o[FRAME_W-1:0] = data_q;
      default:  rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/spi_rx_sck_gen.sv
module spi_rx_sck_gen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             sck_q, tick;

  assign tick   = run_i && (cnt_q == CNT_LAST);
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= !sck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sck_o = sck_q;
endmodule

// File: rtl/spi_rx_engine.sv
module spi_rx_engine
  import spi_rx_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  ctrl_t              ctrl_i,
  input  logic               rd_data_i,
  input  logic               wr_data_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               sdi_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] BIT_PREV = BIT_W'(FRAME_W - 2);

  logic               busy_q, arm_q, active, rx_mode, start, last_bit;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] shift_q;

  assign active   = ctrl_i.pwr && ctrl_i.rx_en;
  assign rx_mode  = !ctrl_i.tx_mode;
  // receive modes: gated read trigger; transmit modes: data write, gate ignored
  assign start    = !busy_q && active &&
                    ((rx_mode && ctrl_i.start_en && rd_data_i) ||
                     (!rx_mode && wr_data_i));
  assign last_bit = (bit_q == BIT_LAST);
  assign done_o   = busy_q && active && fall_i && last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      arm_q   <= 1'b0;
      bit_q   <= '0;
      shift_q <= '0;
    end else if (!active) begin
      busy_q <= 1'b0;
      arm_q  <= 1'b0;
      bit_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      arm_q  <= 1'b0;
      bit_q  <= '0;
    end else if (busy_q) begin
      if (rise_i) shift_q <= {shift_q[FRAME_W-2:0], sdi_i};
      if (fall_i) begin
        if (last_bit) begin
          bit_q  <= '0;
          arm_q  <= 1'b0;
          busy_q <= arm_q;
        end else begin
          bit_q <= bit_q + 1'b1;
          // falling edge that opens the final bit: continuation decision
          if (bit_q == BIT_PREV)
            arm_q <= rx_mode && ctrl_i.cont && ctrl_i.start_en;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign frame_o = shift_q;
endmodule

// File: rtl/spi_rx_start_ctrl.sv
module spi_rx_start_ctrl
  import spi_rx_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [REG_W-1:0]  bus_wdata_i,
  output logic [REG_W-1:0]  bus_rdata_o,
  output logic              sck_o,
  input  logic              sdi_i,
  output logic              rx_irq_o
);
  ctrl_t              ctrl;
  logic               rd_data, wr_data, busy, done, rise, fall, irq_q;
  logic [FRAME_W-1:0] frame;

  spi_rx_regs i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .rdata_o  (bus_rdata_o),
    .busy_i   (busy),
    .done_i   (done),
    .frame_i  (frame),
    .ctrl_o   (ctrl),
    .rd_data_o(rd_data),
    .wr_data_o(wr_data)
  );

  spi_rx_sck_gen #(.DIV_HALF(DIV_HALF)) i_sck (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .sck_o (sck_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  spi_rx_engine i_eng (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctrl_i   (ctrl),
    .rd_data_i(rd_data),
    .wr_data_i(wr_data),
    .rise_i   (rise),
    .fall_i   (fall),
    .sdi_i    (sdi_i),
    .busy_o   (busy),
    .done_o   (done),
    .frame_o  (frame)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= done;
  end

  assign rx_irq_o = irq_q;
endmodule

// File: rtl/spi_rx_start_ctrl_chk.sv
module spi_rx_start_ctrl_chk
  import spi_rx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              sck_i,
  input logic              irq_i,
  input ctrl_t             ctrl_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  rdata_i
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i); // R6
  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> !sck_i); // R3
  AST_START_NEEDS_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(ctrl_i.pwr && ctrl_i.rx_en)); // R7
  AST_RX_START_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_i) && !ctrl_i.tx_mode) |-> $past(ctrl_i.start_en)); // R1
  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_CTRL) |-> (rdata_i[3:1] == 3'b000)); // R9
  AST_OFF_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_i.pwr && ctrl_i.rx_en) |-> !$past(busy_i)); // R7
endmodule

bind spi_rx_start_ctrl spi_rx_start_ctrl_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy),
  .sck_i  (sck_o),
  .irq_i  (rx_irq_o),
  .ctrl_i (ctrl),
  .addr_i (bus_addr_i),
  .rdata_i(bus_rdata_o)
);

// File: tb/test_spi_rx_start_ctrl.sv
module test_spi_rx_start_ctrl;
  localparam int DIV_HALF = 2;
  localparam int NVEC = 6;
  localparam int FRAME_CYC = 16 * DIV_HALF;
  // stimulus byte shifted in by the model slave = expected data register value
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h81, 8'h5A};

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic sck, sdi, irq;

  int checks = 0, fails = 0;
  int cyc = 0, irq_cnt = 0, last_irq = 0;
  int sck_falls = 0, base = 0;

  always #10 clk = !clk;

  spi_rx_start_ctrl #(.DIV_HALF(DIV_HALF)) i_spi_rx_start_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sck_o(sck), .sdi_i(sdi), .rx_irq_o(irq)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (irq) begin
      irq_cnt = irq_cnt + 1;
      last_irq = cyc;
    end
  end

  always @(negedge sck) sck_falls = sck_falls + 1;

  always_comb begin
    int pos;
    pos = sck_falls - base;
    sdi = (pos >= 0 && pos < NVEC * 8) ? VEC[pos / 8][7 - (pos % 8)] : 1'b0;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rdata;
    @(negedge clk);
  endtask

  task automatic wait_irq(output int ok);
    int n0;
    n0 = irq_cnt;
    ok = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (irq_cnt > n0) begin ok = 1; break; end
    end
  endtask

  initial begin
    repeat (1000000 / 20) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int ok, n0, f0, t0;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 sck", sck, 0);
    chk("R11 irq", irq, 0);
    peek(2'd0, d); chk("R11 ctrl", d, 0);
    peek(2'd1, d); chk("R11 stat", d, 0);
    peek(2'd2, d); chk("R11 data", d, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 read with gate off starts nothing
    bus_write(2'd0, 8'hC0);
    bus_read(2'd2, d);
    repeat (10) @(negedge clk);
    peek(2'd1, d); chk("R1 busy", d, 0);
    chk("R1 irq count", irq_cnt, 0);

    // R9 reserved bits
    bus_write(2'd0, 8'hCF);
    peek(2'd0, d); chk("R9 ctrl readback", d, 8'hC1);

    // R2/R3/R6 single-mode vector walk
    base = sck_falls;
    bus_read(2'd2, d);
    peek(2'd1, d); chk("R2 busy after start read", d, 8'h01);
    for (int i = 0; i < NVEC; i++) begin
      wait_irq(ok); chk("R6 irq seen", ok, 1);
      peek(2'd1, d); chk("R6 stat idle full", d, 8'h04);
      if (i == NVEC - 1) bus_write(2'd0, 8'hC0);
      bus_read(2'd2, d); chk("R6 data", d, VEC[i]);
    end
    n0 = irq_cnt; f0 = sck_falls;
    repeat (40) @(negedge clk);
    chk("R3 no irq after last read", irq_cnt, n0);
    chk("R3 sck quiet", sck_falls, f0);
    peek(2'd1, d); chk("R3 stat idle", d, 8'h00);
    chk("R6 one pulse per frame", irq_cnt, NVEC);

    // R8 restart by dummy read
    bus_write(2'd0, 8'hC1);
    base = sck_falls;
    bus_read(2'd2, d);
    wait_irq(ok); chk("R8 restart irq", ok, 1);
    bus_write(2'd0, 8'hC0);
    bus_read(2'd2, d); chk("R8 restart data", d, VEC[0]);

    // R4 continuous, early clear
    bus_write(2'd0, 8'hD1);
    base = sck_falls;
    bus_read(2'd2, d);
    wait_irq(ok); t0 = last_irq;
    bus_read(2'd2, d); chk("R4 cont byte0", d, VEC[0]);
    wait_irq(ok);
    chk("R4 no gap spacing", last_irq - t0, FRAME_CYC);
    bus_read(2'd2, d); chk("R4 cont byte1", d, VEC[1]);
    bus_write(2'd0, 8'hD0);
    wait_irq(ok); chk("R4 final irq", ok, 1);
    bus_read(2'd2, d); chk("R4 cont byte2", d, VEC[2]);
    n0 = irq_cnt;
    repeat (80) @(negedge clk);
    chk("R4 stopped", irq_cnt, n0);
    peek(2'd1, d); chk("R4 idle", d, 8'h00);

    // R4 late clear + R10 overrun
    bus_write(2'd0, 8'hD1);
    base = sck_falls;
    bus_read(2'd2, d);
    wait_irq(ok);
    n0 = irq_cnt;
    bus_read(2'd2, d); chk("R4 late byte0", d, VEC[0]);
    repeat (30) @(negedge clk);
    bus_write(2'd0, 8'hD0);
    repeat (80) @(negedge clk);
    chk("R4 late clear one extra frame", irq_cnt - n0, 2);
    peek(2'd1, d); chk("R10 overrun+full", d, 8'h06);
    bus_read(2'd2, d); chk("R10 overwrite", d, VEC[2]);
    peek(2'd1, d); chk("R10 sticky", d, 8'h02);
    bus_write(2'd1, 8'h02);
    peek(2'd1, d); chk("R10 cleared", d, 8'h00);

    // R5 transmit mode ignores gate
    bus_write(2'd0, 8'hE1);
    n0 = irq_cnt;
    bus_read(2'd2, d);
    repeat (10) @(negedge clk);
    peek(2'd1, d); chk("R5 read no start", d, 8'h00);
    chk("R5 no irq", irq_cnt, n0);
    bus_write(2'd0, 8'hE0);
    base = sck_falls;
    bus_write(2'd2, 8'h00);
    peek(2'd1, d); chk("R5 write starts", d, 8'h01);
    wait_irq(ok); chk("R5 irq", ok, 1);
    bus_read(2'd2, d); chk("R5 data", d, VEC[0]);

    // R7 no start without power
    bus_write(2'd0, 8'h41);
    n0 = irq_cnt;
    bus_read(2'd2, d);
    repeat (10) @(negedge clk);
    peek(2'd1, d); chk("R7 unpowered idle", d, 8'h00);
    chk("R7 no irq", irq_cnt, n0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule